// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block holds an 8-bit count that moves only on a qualified timer tick. A 3-bit source code picks where the tick comes from. It can be one of five prescaler tap pulses, or an edge on an external pin that has passed through a synchronizer. A source code of zero stops the counter. A 2-bit mode code decides the counting sequence. The four sequences are: wrap upward, sweep up and down between the extremes, clear on reaching a limit value, and wrap downward. The mode code also decides when an overflow flag is raised, and that flag can feed an interrupt request.

A CPU reads the count at any time through `cnt_o`, and it can load a new count in any cycle, including while the counter is stopped. A load always wins over the counting action of the same cycle. The flag is cleared either by writing a one to it or by an acknowledge pulse from an interrupt controller. The up/down sweep is run by a two-state direction machine. Its states are SEQ_UP and SEQ_DOWN. TURN_DOWN is taken on a tick at the maximum count while in SEQ_UP. TURN_UP is taken on a tick at zero while in SEQ_DOWN. In the other modes the machine is forced each cycle: to SEQ_DOWN in the down-wrap mode and to SEQ_UP otherwise.

Top module: `tmr_updown_core`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0, `bottom_o` is 1 and `top_o` is 0.
- R2: With source code 0 the count holds, whatever the tap pulses and external pin edges.
- R3: Source codes 1 to 5 take the tick from `pre_tick_i[code-1]` alone, and pulses on the other taps are ignored. Each tick changes the count at the clock edge where the pulse is sampled.
- R4: Source code 7 counts rising edges and code 6 counts falling edges of `ext_clk_i`. Each edge gives one step. The count changes on the third rising clock edge after the pin changes, and a level that holds steady gives no further steps.
- R5: A load (`cnt_wr_i`=1) puts `cnt_wdata_i` into the count at the next edge. It overrides any clear or count action of that cycle and suppresses that cycle's overflow.
- R6: A load takes effect while no tick source is selected.
- R7: `top_o` is 1 exactly when the count is 0xFF, and `bottom_o` is 1 exactly when the count is 0x00.
- R8: Mode 0 counts up, wraps from 0xFF to 0x00, and sets the flag on the wrapping tick.
- R9: Mode 1 counts up to 0xFF and then down to 0x00, turning at each extreme. The flag is set on the tick that turns the counter upward at 0x00.
- R10: Mode 2 counts up and clears to 0x00 on the tick taken when the count equals `lim_i`. The flag is set on a tick taken at 0xFF.
- R11: Mode 3 counts down, wraps from 0x00 to 0xFF, and sets the flag on that wrapping tick.
- R12: The flag clears when `ovf_wr_i`=1 with `ovf_wdata_i`=1, or when `ovf_ack_i`=1. Writing a zero has no effect. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 3 | Tick source: 0 off, 1-5 prescaler tap, 6 external falling, 7 external rising |
| mode_i | input | 2 | Counting sequence: 0 wrap up, 1 up/down, 2 clear at limit, 3 wrap down |
| pre_tick_i | input | 5 | One-cycle pulses from the prescaler taps |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| lim_i | input | 8 | Limit value for mode 2 |
| cnt_wr_i | input | 1 | CPU load strobe for the count |
| cnt_wdata_i | input | 8 | CPU load value |
| cnt_o | output | 8 | Current count, always readable |
| top_o | output | 1 | Count is at its maximum |
| bottom_o | output | 1 | Count is zero |
| ovf_wr_i | input | 1 | CPU write strobe for the flag bit |
| ovf_wdata_i | input | 1 | Flag write data; a one clears the flag |
| ovf_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The hardest situations to reach are the collisions. In one, a CPU load lands in the very cycle that a tick would wrap the count and raise the flag. In the other, a flag clear meets a flag set. Directed tasks get there by first loading the count to the extreme value. They then drive the tap pulse together with the load strobe, or together with the acknowledge, on the same falling clock edge, so that both are sampled at one rising edge. The external pin path adds three edges of delay. The bench samples the count after each of those edges, so that an early or late step is caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned NUM_TAPS = 5;

    typedef enum logic [1:0] {
        MODE_WRAP_UP   = 2'd0,
        MODE_UPDOWN    = 2'd1,
        MODE_MATCH_CLR = 2'd2,
        MODE_WRAP_DOWN = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_CLR  = 2'd3
    } op_e;

    typedef enum logic {
        SEQ_UP   = 1'b0,
        SEQ_DOWN = 1'b1
    } seq_e;

    localparam logic [2:0] SRC_OFF      = 3'd0;
    localparam logic [2:0] SRC_EXT_FALL = 3'd6;
    localparam logic [2:0] SRC_EXT_RISE = 3'd7;

endpackage

// File: rtl/tmr_clk_qual.sv
module tmr_clk_qual
    import tmr_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [2:0]          sel_i,
    input  logic [NUM_TAPS-1:0] taps_i,
    input  logic                ext_i,
    output logic                tick_o
);
    logic                ext_meta_q, ext_sync_q, ext_prev_q;
    logic                ext_rise, ext_fall;
    logic [NUM_TAPS-1:0] tap_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ext_meta_q <= 1'b0;
            ext_sync_q <= 1'b0;
            ext_prev_q <= 1'b0;
        end else begin
            ext_meta_q <= ext_i;
            ext_sync_q <= ext_meta_q;
            ext_prev_q <= ext_sync_q;
        end
    end

    assign ext_rise = ext_sync_q & ~ext_prev_q;
    assign ext_fall = ~ext_sync_q & ext_prev_q;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_hit[g] = taps_i[g] && (sel_i == 3'(g + 1));
    end

    always_comb begin
        tick_o = |tap_hit;
        if (sel_i == SRC_EXT_RISE) tick_o = ext_rise;
        if (sel_i == SRC_EXT_FALL) tick_o = ext_fall;
    end

endmodule

// File: rtl/tmr_seq_ctrl.sv
module tmr_seq_ctrl
    import tmr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       mode_i,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] cnt_i,
    input  logic [WIDTH-1:0] lim_i,
    output op_e              op_o,
    output logic             ovf_evt_o
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    seq_e  state_q, state_d;
    mode_e mode;
    logic  at_max, at_zero;

    assign mode    = mode_e'(mode_i);
    assign at_max  = (cnt_i == CNT_MAX);
    assign at_zero = (cnt_i == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SEQ_UP;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (mode)
            MODE_UPDOWN: begin
                unique case (state_q)
                    SEQ_UP:   if (tick_i && at_max)  state_d = SEQ_DOWN;
                    SEQ_DOWN: if (tick_i && at_zero) state_d = SEQ_UP;
                    default:  state_d = SEQ_UP;
                endcase
            end
            MODE_WRAP_DOWN: state_d = SEQ_DOWN;
            default:        state_d = SEQ_UP;
        endcase
    end

    always_comb begin
        op_o      = OP_HOLD;
        ovf_evt_o = 1'b0;
        if (tick_i) begin
            unique case (mode)
                MODE_WRAP_UP: begin
                    op_o      = OP_INC;
                    ovf_evt_o = at_max;
                end
                MODE_UPDOWN: begin
                    if (state_q == SEQ_UP) begin
                        op_o = at_max ? OP_DEC : OP_INC;
                    end else if (at_zero) begin
                        op_o      = OP_INC;
                        ovf_evt_o = 1'b1;
                    end else begin
                        op_o = OP_DEC;
                    end
                end
                MODE_MATCH_CLR: begin
                    op_o      = (cnt_i == lim_i) ? OP_CLR : OP_INC;
                    ovf_evt_o = at_max;
                end
                MODE_WRAP_DOWN: begin
                    op_o      = OP_DEC;
                    ovf_evt_o = at_zero;
                end
                default: op_o = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/tmr_cnt_reg.sv
module tmr_cnt_reg
    import tmr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  op_e              op_i,
    input  logic             ovf_evt_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             flag_wr_i,
    input  logic             flag_wdata_i,
    input  logic             ack_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             ovf_o
);
    logic flag_set, flag_clr;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (wr_i) begin
            cnt_o <= wdata_i;
        end else begin
            unique case (op_i)
                OP_INC:  cnt_o <= cnt_o + 1'b1;
                OP_DEC:  cnt_o <= cnt_o - 1'b1;
                OP_CLR:  cnt_o <= '0;
                default: cnt_o <= cnt_o;
            endcase
        end
    end

    assign flag_set = ovf_evt_i & ~wr_i;
    assign flag_clr = (flag_wr_i & flag_wdata_i) | ack_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       ovf_o <= 1'b0;
        else if (flag_set) ovf_o <= 1'b1;
        else if (flag_clr) ovf_o <= 1'b0;
    end

endmodule

// File: rtl/tmr_updown_core.sv
module tmr_updown_core
    import tmr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [2:0]          clk_sel_i,
    input  logic [1:0]          mode_i,
    input  logic [NUM_TAPS-1:0] pre_tick_i,
    input  logic                ext_clk_i,
    input  logic [WIDTH-1:0]    lim_i,
    input  logic                cnt_wr_i,
    input  logic [WIDTH-1:0]    cnt_wdata_i,
    output logic [WIDTH-1:0]    cnt_o,
    output logic                top_o,
    output logic                bottom_o,
    input  logic                ovf_wr_i,
    input  logic                ovf_wdata_i,
    input  logic                ovf_ack_i,
    output logic                ovf_o
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    logic tick;
    op_e  op;
    logic ovf_evt;

    tmr_clk_qual u_qual (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (clk_sel_i),
        .taps_i (pre_tick_i),
        .ext_i  (ext_clk_i),
        .tick_o (tick)
    );

    tmr_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode_i),
        .tick_i    (tick),
        .cnt_i     (cnt_o),
        .lim_i     (lim_i),
        .op_o      (op),
        .ovf_evt_o (ovf_evt)
    );

    tmr_cnt_reg #(.WIDTH(WIDTH)) u_cnt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .op_i         (op),
        .ovf_evt_i    (ovf_evt),
        .wr_i         (cnt_wr_i),
        .wdata_i      (cnt_wdata_i),
        .flag_wr_i    (ovf_wr_i),
        .flag_wdata_i (ovf_wdata_i),
        .ack_i        (ovf_ack_i),
        .cnt_o        (cnt_o),
        .ovf_o        (ovf_o)
    );

    assign top_o    = (cnt_o == CNT_MAX);
    assign bottom_o = (cnt_o == '0);

endmodule

// File: rtl/tmr_updown_core_chk.sv
module tmr_updown_core_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [2:0]       clk_sel_i,
    input logic [1:0]       mode_i,
    input logic [4:0]       pre_tick_i,
    input logic             ext_clk_i,
    input logic [WIDTH-1:0] lim_i,
    input logic             cnt_wr_i,
    input logic [WIDTH-1:0] cnt_wdata_i,
    input logic [WIDTH-1:0] cnt_o,
    input logic             top_o,
    input logic             bottom_o,
    input logic             ovf_wr_i,
    input logic             ovf_wdata_i,
    input logic             ovf_ack_i,
    input logic             ovf_o
);
    // R5: a load reaches the count at the next edge
    a_r5_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)));

    // R5: the flag never rises after a cycle that carried a load
    a_r5_no_ovf_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> !$past(cnt_wr_i));

    // R2: a stopped counter keeps its value
    a_r2_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_sel_i == 3'd0 && !cnt_wr_i) |=> $stable(cnt_o));

    // R7: the two extreme indicators never coincide
    a_r7_top_bottom_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(top_o && bottom_o));

    // R8: wrap-up mode moves by zero or plus one
    a_r8_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd0 && !cnt_wr_i) |=>
            (cnt_o == $past(cnt_o) || cnt_o == WIDTH'($past(cnt_o) + 1'b1)));

    // R11: wrap-down mode moves by zero or minus one
    a_r11_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd3 && !cnt_wr_i) |=>
            (cnt_o == $past(cnt_o) || cnt_o == WIDTH'($past(cnt_o) - 1'b1)));

    // R12: the acknowledge clears a set flag unless a new overflow arrives
    a_r12_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && ovf_ack_i && !top_o && !bottom_o) |=> !ovf_o);

endmodule

bind tmr_updown_core tmr_updown_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tmr_updown_core_bench.sv
`timescale 1ns/1ps
module tmr_updown_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic [1:0] mode = 2'd0;
    logic [4:0] pre_tick = '0;
    logic       ext_clk = 1'b0;
    logic [7:0] lim = 8'd0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = 8'd0;
    logic [7:0] cnt;
    logic       top, bottom;
    logic       ovf_wr = 1'b0, ovf_wdata = 1'b0, ovf_ack = 1'b0;
    logic       ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_updown_core u_tmr_updown_core (
        .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .mode_i(mode),
        .pre_tick_i(pre_tick), .ext_clk_i(ext_clk), .lim_i(lim),
        .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .cnt_o(cnt),
        .top_o(top), .bottom_o(bottom), .ovf_wr_i(ovf_wr),
        .ovf_wdata_i(ovf_wdata), .ovf_ack_i(ovf_ack), .ovf_o(ovf)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load(int v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 8'(v);
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic pulse_tap(int idx);
        @(negedge clk); pre_tick = 5'(1 << idx);
        @(negedge clk); pre_tick = '0;
    endtask

    task automatic clr_flag();
        @(negedge clk); ovf_wr = 1'b1; ovf_wdata = 1'b1;
        @(negedge clk); ovf_wr = 1'b0; ovf_wdata = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "count", cnt, 0);
        check("R1", "flag", ovf, 0);
        check("R1", "bottom", bottom, 1);
        check("R1", "top", top, 0);
    endtask

    task automatic t_stopped();
        clk_sel = 3'd0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); pre_tick = 5'h1F; ext_clk = ~ext_clk;
        end
        @(negedge clk); pre_tick = '0; ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        check("R2", "stopped count", cnt, 0);
        load(8'h5A);
        check("R6", "load while stopped", cnt, 8'h5A);
    endtask

    task automatic t_taps();
        clk_sel = 3'd3;
        pulse_tap(0); pulse_tap(1); pulse_tap(3); pulse_tap(4);
        check("R3", "other taps ignored", cnt, 8'h5A);
        for (int i = 0; i < 3; i++) pulse_tap(2);
        check("R3", "selected tap counts", cnt, 8'h5D);
    endtask

    task automatic t_ext();
        clk_sel = 3'd7;
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); check("R4", "rise edge+1", cnt, 8'h5D);
        @(negedge clk); check("R4", "rise edge+2", cnt, 8'h5D);
        @(negedge clk); check("R4", "rise edge+3", cnt, 8'h5E);
        repeat (4) @(negedge clk);
        check("R4", "steady high", cnt, 8'h5E);
        clk_sel = 3'd6;
        @(negedge clk); ext_clk = 1'b0;
        @(negedge clk); check("R4", "fall edge+1", cnt, 8'h5E);
        @(negedge clk); check("R4", "fall edge+2", cnt, 8'h5E);
        @(negedge clk); check("R4", "fall edge+3", cnt, 8'h5F);
        repeat (4) @(negedge clk);
        check("R4", "steady low", cnt, 8'h5F);
    endtask

    task automatic t_normal();
        clk_sel = 3'd1; mode = 2'd0;
        load(8'hFE);
        pulse_tap(0);
        check("R8", "up step", cnt, 8'hFF);
        check("R7", "top at max", top, 1);
        check("R8", "no flag before wrap", ovf, 0);
        pulse_tap(0);
        check("R8", "wrap value", cnt, 8'h00);
        check("R8", "flag on wrap", ovf, 1);
        check("R7", "bottom at zero", bottom, 1);
    endtask

    task automatic t_flag();
        @(negedge clk); ovf_wr = 1'b1; ovf_wdata = 1'b0;
        @(negedge clk); ovf_wr = 1'b0;
        check("R12", "write zero keeps flag", ovf, 1);
        clr_flag();
        check("R12", "write one clears", ovf, 0);
        load(8'hFF); pulse_tap(0);
        check("R12", "flag set again", ovf, 1);
        @(negedge clk); ovf_ack = 1'b1;
        @(negedge clk); ovf_ack = 1'b0;
        check("R12", "ack clears", ovf, 0);
        load(8'hFF);
        @(negedge clk); pre_tick = 5'h01; ovf_ack = 1'b1;
        @(negedge clk); pre_tick = '0; ovf_ack = 1'b0;
        check("R12", "set wins over ack", ovf, 1);
        clr_flag();
    endtask

    task automatic t_write_prio();
        load(8'hFF);
        @(negedge clk); pre_tick = 5'h01; cnt_wr = 1'b1; cnt_wdata = 8'h10;
        @(negedge clk); pre_tick = '0; cnt_wr = 1'b0;
        check("R5", "load beats tick", cnt, 8'h10);
        check("R5", "no flag on load", ovf, 0);
        pulse_tap(0);
        check("R5", "counting resumes", cnt, 8'h11);
    endtask

    task automatic t_updown();
        mode = 2'd1;
        load(8'hFE);
        pulse_tap(0); check("R9", "up to max", cnt, 8'hFF);
        pulse_tap(0); check("R9", "turn down", cnt, 8'hFE);
        check("R9", "no flag at top", ovf, 0);
        load(8'h01);
        pulse_tap(0); check("R9", "down to zero", cnt, 8'h00);
        check("R9", "no flag yet", ovf, 0);
        pulse_tap(0); check("R9", "turn up", cnt, 8'h01);
        check("R9", "flag at bottom turn", ovf, 1);
        pulse_tap(0); check("R9", "keeps rising", cnt, 8'h02);
        clr_flag();
    endtask

    task automatic t_match();
        mode = 2'd2; lim = 8'h05;
        load(8'h03);
        pulse_tap(0); pulse_tap(0);
        check("R10", "reach limit", cnt, 8'h05);
        pulse_tap(0); check("R10", "clear at limit", cnt, 8'h00);
        check("R10", "no flag below max", ovf, 0);
        lim = 8'hFF;
        load(8'hFE);
        pulse_tap(0); pulse_tap(0);
        check("R10", "clear at max limit", cnt, 8'h00);
        check("R10", "flag at max", ovf, 1);
        clr_flag();
    endtask

    task automatic t_down();
        mode = 2'd3;
        load(8'h01);
        pulse_tap(0); check("R11", "down step", cnt, 8'h00);
        check("R11", "no flag at zero", ovf, 0);
        pulse_tap(0); check("R11", "wrap to max", cnt, 8'hFF);
        check("R11", "flag on wrap", ovf, 1);
        pulse_tap(0); check("R11", "continue down", cnt, 8'hFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_taps();
        t_ext();
        t_normal();
        t_flag();
        t_write_prio();
        t_updown();
        t_match();
        t_down();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule